// File: doc/BRIEF.md
# Arithmetic status flag unit

This block performs byte-wide and word-wide addition and subtraction and keeps the processor flags word that results from them. A request selects one of four operations: plain add, add with carry, plain subtract, or subtract with borrow. It also selects byte or word width, and supplies two 16-bit operands and a carry-in bit. On the next clock edge the block registers the result together with six status flags. The flags record carry or borrow, low-byte parity, nibble carry for decimal adjustment, zero, sign and signed overflow.

Three control flags sit in the same word: single-step trap, interrupt enable and string direction. Arithmetic never touches them. They change only through per-bit set and clear commands, or through a load of the whole flags word. The flags word has a fixed sparse layout of 16 bits with nine live positions. The other positions always read as zero, so software can save and restore the word as a whole.

Top module: `arith_flag_unit`

## Requirements
- R1: While rst_n is low, and at the first sample after it rises, `result` and `flags` are both 0.
- R2: Flag positions in `flags` are carry 0, parity 2, nibble carry 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10 and overflow 11. Every other bit reads 0 at all times, even after a load of 16'hFFFF.
- R3: When op_valid is high, `op_sel` selects the operation: 0 add, 1 add with carry_in, 2 subtract, 3 subtract with borrow carry_in. The result appears at `result` after the next rising edge. With word_mode low, only bits 7:0 of each operand are used and result[15:8] is 0.
- R4: The carry flag is the carry out of bit 7 (byte) or bit 15 (word) on addition, and the borrow into that bit on subtraction.
- R5: The parity flag is 1 when result[7:0] holds an even number of ones, in both widths.
- R6: The nibble carry flag is the carry or borrow out of bit 3.
- R7: The zero flag is 1 when the result at the selected width is 0. The sign flag equals bit 7 (byte) or bit 15 (word) of the result.
- R8: The overflow flag is 1 when the two's-complement result falls outside -128..127 (byte) or -32768..32767 (word).
- R9: When op_valid and load_en are both low, all six status flags keep their values, and so does `result`.
- R10: ctl_set and ctl_clr each act on the control flags: bit 0 is trap, bit 1 is interrupt enable, bit 2 is direction. If both commands hit the same bit, set wins. Arithmetic operations leave the control flags unchanged.
- R11: When load_en is high, the nine live flags take the matching bits of load_word on the next edge. This takes priority over status updates and control commands issued in the same cycle, but `result` still follows op_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform the selected arithmetic this cycle |
| op_sel | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| word_mode | input | 1 | 1 selects word width, 0 byte width |
| opnd_a | input | 16 | First operand (minuend for subtraction) |
| opnd_b | input | 16 | Second operand (subtrahend for subtraction) |
| carry_in | input | 1 | Carry or borrow used by operations 1 and 3 |
| ctl_set | input | 3 | Per-bit set command for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Per-bit clear command for the same three flags |
| load_en | input | 1 | Replace the whole flags word from load_word |
| load_word | input | 16 | Value loaded into the flags word |
| result | output | 16 | Registered arithmetic result |
| flags | output | 16 | Registered flags word |

## Verification
Assertions check four things on every cycle. Dead flag positions stay zero. Status flags and result hold when there is no operation or load, and control flags hold when no command or load arrives. After each operation, the registered zero and parity flags agree with the registered result, and a byte operation clears the upper result byte. Some behaviour needs known operand values, so only the bench's scenarios can show it. This covers correct carry, borrow, nibble carry and overflow at the 7F/80 and FF/00 boundaries of both widths, the effect of carry_in on the two carry-using operations, set-over-clear priority, and load priority over a concurrent operation.

// File: rtl/flag_pkg.sv
package flag_pkg;
    localparam int FLAG_W = 16;
    localparam int CTL_N  = 3;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    localparam logic [FLAG_W-1:0] LIVE_MASK = 16'h0FD5;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_ADC = 2'd1,
        OP_SUB = 2'd2,
        OP_SBB = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } status_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
    import flag_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  alu_op_e       op_i,
    input  logic          wide_i,
    output logic [DW-1:0] res_o,
    output status_t       st_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] a_m;
    logic [DW-1:0] b_m;
    logic [DW:0]   full;
    logic          is_sub;
    logic          use_c;
    logic          sa, sb, sr;

    always_comb begin
        a_m    = wide_i ? a_i : {{HW{1'b0}}, a_i[HW-1:0]};
        b_m    = wide_i ? b_i : {{HW{1'b0}}, b_i[HW-1:0]};
        is_sub = (op_i == OP_SUB) || (op_i == OP_SBB);
        use_c  = ((op_i == OP_ADC) || (op_i == OP_SBB)) && cin_i;
        if (is_sub)
            full = {1'b0, a_m} - {1'b0, b_m} - {{DW{1'b0}}, use_c};
        else
            full = {1'b0, a_m} + {1'b0, b_m} + {{DW{1'b0}}, use_c};
        res_o  = wide_i ? full[DW-1:0] : {{HW{1'b0}}, full[HW-1:0]};
        sa     = wide_i ? a_m[DW-1]   : a_m[HW-1];
        sb     = wide_i ? b_m[DW-1]   : b_m[HW-1];
        sr     = wide_i ? res_o[DW-1] : res_o[HW-1];
        st_o.cf = wide_i ? full[DW] : full[HW];
        st_o.pf = ~^res_o[7:0];
        st_o.af = a_m[4] ^ b_m[4] ^ res_o[4];
        st_o.zf = (res_o == '0);
        st_o.sf = sr;
        st_o.of = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    end
endmodule

// File: rtl/ctrl_bits.sv
module ctrl_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         load_i,
    input  logic [N-1:0] load_val_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (load_i)
                q_o[g] <= load_val_i[g];
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic              word_mode,
    input  logic [FLAG_W-1:0] opnd_a,
    input  logic [FLAG_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic [CTL_N-1:0]  ctl_set,
    input  logic [CTL_N-1:0]  ctl_clr,
    input  logic              load_en,
    input  logic [FLAG_W-1:0] load_word,
    output logic [FLAG_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] calc_res;
    status_t           calc_st;
    status_t           st_q;
    status_t           st_load;
    logic [CTL_N-1:0]  ctl_q;
    logic [CTL_N-1:0]  ctl_load;

    flag_calc #(.DW(FLAG_W)) u_calc (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .cin_i  (carry_in),
        .op_i   (alu_op_e'(op_sel)),
        .wide_i (word_mode),
        .res_o  (calc_res),
        .st_o   (calc_st)
    );

    assign ctl_load = {load_word[POS_DF], load_word[POS_IF], load_word[POS_TF]};

    ctrl_bits #(.N(CTL_N)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ctl_set),
        .clr_i      (ctl_clr),
        .load_i     (load_en),
        .load_val_i (ctl_load),
        .q_o        (ctl_q)
    );

    always_comb begin
        st_load.cf = load_word[POS_CF];
        st_load.pf = load_word[POS_PF];
        st_load.af = load_word[POS_AF];
        st_load.zf = load_word[POS_ZF];
        st_load.sf = load_word[POS_SF];
        st_load.of = load_word[POS_OF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            result <= '0;
        end else begin
            if (op_valid)
                result <= calc_res;
            if (load_en)
                st_q <= st_load;
            else if (op_valid)
                st_q <= calc_st;
        end
    end

    always_comb begin
        flags         = '0;
        flags[POS_CF] = st_q.cf;
        flags[POS_PF] = st_q.pf;
        flags[POS_AF] = st_q.af;
        flags[POS_ZF] = st_q.zf;
        flags[POS_SF] = st_q.sf;
        flags[POS_TF] = ctl_q[0];
        flags[POS_IF] = ctl_q[1];
        flags[POS_DF] = ctl_q[2];
        flags[POS_OF] = st_q.of;
    end

    assert_dead_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~LIVE_MASK) == '0);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !load_en) |=> ($stable(st_q) && $stable(result)));

    assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && ctl_set == '0 && ctl_clr == '0) |=> $stable(ctl_q));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !load_en) |=> (flags[POS_ZF] == (result == '0)));

    assert_parity_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !load_en) |=> (flags[POS_PF] == ~^result[7:0]));

    assert_byte_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !word_mode) |=> (result[15:8] == 8'h00));
endmodule

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic        word_mode = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [2:0]  ctl_set = '0;
    logic [2:0]  ctl_clr = '0;
    logic        load_en = 1'b0;
    logic [15:0] load_word = '0;
    logic [15:0] result;
    logic [15:0] flags;

    int n_chk = 0;
    int n_bad = 0;
    int m_res = 0;
    int m_flags = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    arith_flag_unit u_arith_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .load_en(load_en), .load_word(load_word), .result(result), .flags(flags)
    );

    task automatic compare(string tag);
        n_chk++;
        if (int'(result) != m_res || int'(flags) != m_flags) begin
            n_bad++;
            $display("FAIL %s: result=%h expected %h, flags=%h expected %h",
                     tag, result, m_res[15:0], flags, m_flags[15:0]);
        end
    endtask

    task automatic step(string tag, bit v, int op, bit w, int a, int b, bit c,
                        int st, int cl, bit ld, int lw);
        int mask, hb, am, bm, cc, full, r, cf, pf, af, zf, sf, ofl, sa, sb, sr, ones, nf;
        op_valid = v; op_sel = op[1:0]; word_mode = w; opnd_a = a[15:0];
        opnd_b = b[15:0]; carry_in = c; ctl_set = st[2:0]; ctl_clr = cl[2:0];
        load_en = ld; load_word = lw[15:0];
        nf = m_flags;
        if (v) begin
            mask = w ? 32'hFFFF : 32'hFF;
            hb = w ? 15 : 7;
            am = a & mask; bm = b & mask;
            cc = (op == 1 || op == 3) ? int'(c) : 0;
            if (op >= 2) begin full = am - bm - cc; cf = (full < 0) ? 1 : 0; end
            else begin full = am + bm + cc; cf = (full > mask) ? 1 : 0; end
            r = full & mask;
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            pf = (ones % 2 == 0) ? 1 : 0;
            af = ((am ^ bm ^ r) >> 4) & 1;
            zf = (r == 0) ? 1 : 0;
            sa = (am >> hb) & 1; sb = (bm >> hb) & 1; sr = (r >> hb) & 1;
            sf = sr;
            if (op >= 2) ofl = (sa != sb && sr != sa) ? 1 : 0;
            else         ofl = (sa == sb && sr != sa) ? 1 : 0;
            m_res = r;
            nf = (nf & 32'h0700) | cf | (pf << 2) | (af << 4) | (zf << 6)
                 | (sf << 7) | (ofl << 11);
        end
        if (ld) nf = lw & 32'h0FD5;
        else begin
            for (int k = 0; k < 3; k++) begin
                if ((st >> k) & 1) nf = nf | (1 << (8 + k));
                else if ((cl >> k) & 1) nf = nf & ~(1 << (8 + k));
            end
        end
        @(posedge clk);
        m_flags = nf;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // R4 R6 R8: byte 7F+01 -> 80, overflow, nibble carry, sign
        step("R8 byte add overflow", 1, 0, 0, 16'h007F, 16'h0001, 0, 0, 0, 0, 0);
        // R4 R7: byte FF+01 -> 00 carry, zero, parity
        step("R4 byte add carry", 1, 0, 0, 16'h12FF, 16'h3401, 0, 0, 0, 0, 0);
        step("R4 word add carry", 1, 0, 1, 16'hFFFF, 16'h0001, 0, 0, 0, 0, 0);
        step("R8 word add overflow", 1, 0, 1, 16'h7FFF, 16'h0001, 0, 0, 0, 0, 0);
        step("R8 word sub overflow", 1, 2, 1, 16'h8000, 16'h0001, 0, 0, 0, 0, 0);
        step("R4 byte sub borrow", 1, 2, 0, 16'h0000, 16'h0001, 0, 0, 0, 0, 0);
        step("R6 byte sub nibble borrow", 1, 2, 0, 16'h0010, 16'h0001, 0, 0, 0, 0, 0);
        step("R3 adc carry_in", 1, 1, 1, 16'h00FF, 16'h0000, 1, 0, 0, 0, 0);
        step("R3 add ignores carry_in", 1, 0, 1, 16'h00FF, 16'h0000, 1, 0, 0, 0, 0);
        step("R3 sbb borrow_in", 1, 3, 0, 16'h0001, 16'h0001, 1, 0, 0, 0, 0);
        step("R5 word parity low byte", 1, 0, 1, 16'h00FF, 16'h0001, 0, 0, 0, 0, 0);
        step("R7 word sign", 1, 2, 1, 16'h0000, 16'h0002, 0, 0, 0, 0, 0);
        idle("R9 hold");
        idle("R9 hold again");
        step("R10 set all", 1, 0, 1, 16'h1234, 16'h4321, 0, 7, 0, 0, 0);
        step("R10 op keeps ctl", 1, 2, 0, 16'h0005, 16'h0009, 1, 0, 0, 0, 0);
        step("R10 clear interrupt", 0, 0, 0, 0, 0, 0, 0, 2, 0, 0);
        step("R10 set wins", 0, 0, 0, 0, 0, 0, 5, 5, 0, 0);
        step("R2 load all ones", 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFF);
        step("R11 load beats op and ctl", 1, 0, 1, 16'h8000, 16'h8000, 0, 7, 7, 1, 16'h0000);
        step("R11 load pattern", 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hA5A5);
        idle("R2 R9 hold after load");

        for (int t = 0; t < 3000; t++) begin
            int rr;
            rr = int'($urandom_range(0, 15));
            step("RAND mixed", (rr != 0), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
                 (rr == 1) ? int'($urandom_range(0, 7)) : 0,
                 (rr == 2 || rr == 1) ? int'($urandom_range(0, 7)) : 0,
                 (rr == 3), int'($urandom_range(0, 65535)));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule